// File: doc/BRIEF.md
# Low-Power SDR SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a low-power single-data-rate SDRAM from the moment reset is released until the memory can accept normal traffic. It first holds the bus idle with clock-enable and data-mask high for a stabilization pause of at least 200 µs. It then issues a precharge of all banks, loads the standard and the extended mode registers, and runs a programmable number (at least two) of dummy auto-refresh cycles. A parameter moves the pair of mode-register loads to either side of the refresh burst. When the wait after the final command has elapsed, it raises `init_done` and keeps it high. After that the controller that shares the bus may take over.

Every minimum gap is supplied in nanoseconds together with the clock period in picoseconds. The gap is converted to clock cycles by dividing and rounding any fraction up, with a floor of two cycles. Each command occupies one cycle, and the next command appears exactly that many cycles later. All cycles between commands carry the idle (NOP) encoding. Both mode-register values are parameters.

The controller is a single state machine with these states:
- `S_PAUSE`: power-up wait.
- `S_PALL`, `S_MRS`, `S_EMRS`, `S_AREF`: one-cycle command states.
- `S_TRP`, `S_TMRD_M`, `S_TMRD_E`, `S_TRC`: gap states.
- `S_DONE`: terminal state.

Its transitions are:
- `S_PAUSE`→`S_PALL` when the pause count expires.
- `S_PALL`→`S_TRP`, `S_MRS`→`S_TMRD_M`, `S_EMRS`→`S_TMRD_E` and `S_AREF`→`S_TRC`, each unconditionally.
- `S_TRP`→`S_MRS` when the mode loads come first, otherwise `S_TRP`→`S_AREF`.
- `S_TMRD_M`→`S_EMRS`.
- `S_TMRD_E`→`S_AREF` when the mode loads come first, otherwise `S_TMRD_E`→`S_DONE`.
- `S_TRC`→`S_AREF` while refreshes remain. Once they are done, `S_TRC`→`S_DONE` when the mode loads came first, otherwise `S_TRC`→`S_MRS`.
- A synchronous reset returns any state to `S_PAUSE`.

Top module: `sdr_pwrup_seq`

## Requirements
- R1: From reset, throughout the pause and in every cycle between commands and after completion, the command pins encode NOP: cs_n=0, ras_n=1, cas_n=1, we_n=1.
- R2: The first non-NOP command appears exactly ceil(200 µs / clock period) cycles after reset release. Cycle 0 is the first cycle with reset low.
- R3: cke and dqm are high in every cycle, during reset and before init_done.
- R4: The first command is precharge-all, encoded cs_n=0, ras_n=0, cas_n=1, we_n=0, with addr[10]=1.
- R5: Mode register load is encoded cs_n=0, ras_n=0, cas_n=0, we_n=0 with ba=0 and addr=MODE_VAL. Extended mode register load uses the same encoding with only the top ba bit set and addr=EXT_MODE_VAL. It follows the mode register load as the next command.
- R6: Exactly max(REF_COUNT,2) auto-refresh commands are issued, encoded cs_n=0, ras_n=0, cas_n=0, we_n=1.
- R7: With MRS_FIRST=1 the order is precharge, mode, extended mode, refreshes. With MRS_FIRST=0 the order is precharge, refreshes, mode, extended mode.
- R8: The gap from a command to the next is exactly ceil(t/period) cycles with a floor of 2. t is T_RP_NS after precharge, T_MRD_NS after either mode load, and T_RC_NS after a refresh.
- R9: init_done rises in the cycle when the gap after the last command expires, then stays high while no further commands are issued.
- R10: A synchronous reset at any point drops init_done on the next cycle and restarts the whole sequence from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, restarts the sequence |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable, held high |
| dqm | output | 1 | Data mask, held high |
| ba | output | BA_W | Bank address, selects standard or extended mode register |
| addr | output | ADDR_W | Address bus, carries A10 and mode values |
| init_done | output | 1 | High once initialization has completed |

## Verification
Two instances run side by side, one with the mode loads ahead of two refreshes and one with them behind three refreshes. This shows whether a design ignores the ordering parameter or miscounts refreshes. Every command is logged with its cycle and compared against an independently computed schedule, so an off-by-one in the ceiling conversion or in a gap counter shows up as a command one cycle early or late. The bench also checks the wrong bank bit on the extended load and a missing A10 on the precharge. A reset issued in the middle of the sequence must clear `init_done` at once and replay the full 200 µs pause; a design that resumes where it stopped issues its precharge early. After completion the bench watches for stray commands and for `init_done` dropping.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_PALL,
        CMD_MRS,
        CMD_EMRS,
        CMD_AREF
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        S_PAUSE,
        S_PALL,
        S_TRP,
        S_MRS,
        S_TMRD_M,
        S_EMRS,
        S_TMRD_E,
        S_AREF,
        S_TRC,
        S_DONE
    } init_state_e;

    // Nanoseconds to whole cycles, fractions rounded up, never fewer than two.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned period_ps);
        int unsigned c;
        c = (t_ns * 1000 + period_ps - 1) / period_ps;
        if (c < 2) c = 2;
        return c;
    endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    AST_TIMER_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && $past(cnt) != '0) |-> (cnt == $past(cnt) - 1'b1)); // R8

endmodule

// File: rtl/sdr_cmd_encoder.sv
module sdr_cmd_encoder
    import sdr_init_pkg::*;
#(
    parameter int unsigned ADDR_W       = 13,
    parameter int unsigned BA_W         = 2,
    parameter logic [ADDR_W-1:0] MODE_VAL     = '0,
    parameter logic [ADDR_W-1:0] EXT_MODE_VAL = '0
) (
    input  sdr_cmd_e          cmd,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [BA_W-1:0] EXT_BA = {1'b1, {(BA_W-1){1'b0}}};

    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = '0;
        addr  = '0;
        unique case (cmd)
            CMD_NOP: begin
            end
            CMD_PALL: begin
                ras_n    = 1'b0;
                we_n     = 1'b0;
                addr[10] = 1'b1;
            end
            CMD_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr  = MODE_VAL;
            end
            CMD_EMRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                ba    = EXT_BA;
                addr  = EXT_MODE_VAL;
            end
            CMD_AREF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sdr_pwrup_seq.sv
module sdr_pwrup_seq
    import sdr_init_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned T_PAUSE_NS    = 200000,
    parameter int unsigned T_RP_NS       = 18,
    parameter int unsigned T_RC_NS       = 60,
    parameter int unsigned T_MRD_NS      = 16,
    parameter int unsigned REF_COUNT     = 2,
    parameter bit          MRS_FIRST     = 1'b1,
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned BA_W          = 2,
    parameter logic [ADDR_W-1:0] MODE_VAL     = 13'h0032,
    parameter logic [ADDR_W-1:0] EXT_MODE_VAL = 13'h0020
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic              dqm,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int unsigned PAUSE_CYC = ns_to_cycles(T_PAUSE_NS, CLK_PERIOD_PS);
    localparam int unsigned RP_CYC    = ns_to_cycles(T_RP_NS, CLK_PERIOD_PS);
    localparam int unsigned RC_CYC    = ns_to_cycles(T_RC_NS, CLK_PERIOD_PS);
    localparam int unsigned MRD_CYC   = ns_to_cycles(T_MRD_NS, CLK_PERIOD_PS);
    localparam int unsigned REF_N     = (REF_COUNT < 2) ? 2 : REF_COUNT;
    localparam int unsigned CNT_W     = $clog2(PAUSE_CYC + 1);
    localparam int unsigned REF_W     = $clog2(REF_N + 1);
    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(RP_CYC - 2);
    localparam logic [CNT_W-1:0] RC_LOAD  = CNT_W'(RC_CYC - 2);
    localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(MRD_CYC - 2);

    init_state_e      state, nxt;
    sdr_cmd_e         cmd;
    logic [REF_W-1:0] ref_cnt;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_exp;

    sdr_gap_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PAUSE_CYC - 1)
    ) gap_tmr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .expired  (tmr_exp)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_PAUSE;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)                  ref_cnt <= '0;
        else if (state == S_AREF) ref_cnt <= ref_cnt + 1'b1;
    end

    // Next state and gap timer loading
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            S_PAUSE:  if (tmr_exp) nxt = S_PALL;
            S_PALL: begin
                tmr_load = 1'b1;
                tmr_val  = RP_LOAD;
                nxt      = S_TRP;
            end
            S_TRP:    if (tmr_exp) nxt = MRS_FIRST ? S_MRS : S_AREF;
            S_MRS: begin
                tmr_load = 1'b1;
                tmr_val  = MRD_LOAD;
                nxt      = S_TMRD_M;
            end
            S_TMRD_M: if (tmr_exp) nxt = S_EMRS;
            S_EMRS: begin
                tmr_load = 1'b1;
                tmr_val  = MRD_LOAD;
                nxt      = S_TMRD_E;
            end
            S_TMRD_E: if (tmr_exp) nxt = MRS_FIRST ? S_AREF : S_DONE;
            S_AREF: begin
                tmr_load = 1'b1;
                tmr_val  = RC_LOAD;
                nxt      = S_TRC;
            end
            S_TRC: begin
                if (tmr_exp) begin
                    if (ref_cnt < REF_W'(REF_N)) nxt = S_AREF;
                    else                         nxt = MRS_FIRST ? S_DONE : S_MRS;
                end
            end
            S_DONE:   nxt = S_DONE;
            default:  nxt = S_PAUSE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state)
            S_PALL:  cmd = CMD_PALL;
            S_MRS:   cmd = CMD_MRS;
            S_EMRS:  cmd = CMD_EMRS;
            S_AREF:  cmd = CMD_AREF;
            default: cmd = CMD_NOP;
        endcase
    end

    assign cke       = 1'b1;
    assign dqm       = 1'b1;
    assign init_done = (state == S_DONE);

    sdr_cmd_encoder #(
        .ADDR_W       (ADDR_W),
        .BA_W         (BA_W),
        .MODE_VAL     (MODE_VAL),
        .EXT_MODE_VAL (EXT_MODE_VAL)
    ) enc_i (
        .cmd   (cmd),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .addr  (addr)
    );

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state inside {S_PAUSE, S_TRP, S_TMRD_M, S_TMRD_E, S_TRC, S_DONE})
        |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111)); // R1
    AST_PALL_A10: assert property (@(posedge clk) disable iff (rst)
        (state == S_PALL) |-> (addr[10] && !cs_n && !ras_n && cas_n && !we_n)); // R4
    AST_MRS_BANK: assert property (@(posedge clk) disable iff (rst)
        (state == S_MRS) |-> (ba == '0 && addr == MODE_VAL)); // R5
    AST_EMRS_BANK: assert property (@(posedge clk) disable iff (rst)
        (state == S_EMRS) |-> (ba[BA_W-1] && addr == EXT_MODE_VAL)); // R5
    AST_REF_BOUND: assert property (@(posedge clk) disable iff (rst)
        ref_cnt <= REF_W'(REF_N)); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R9
    AST_RESTART: assert property (@(posedge clk)
        rst |=> !init_done); // R10

endmodule

// File: tb/sdr_pwrup_seq_tb_top.sv
module sdr_pwrup_seq_tb_top;

    localparam int PER_PS = 8000;
    localparam int K_PALL = 1, K_MRS = 2, K_EMRS = 3, K_REF = 4, K_BAD = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        cs_n[2], ras_n[2], cas_n[2], we_n[2], cke[2], dqm[2], done[2];
    logic [1:0]  ba[2];
    logic [12:0] addr[2];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int n_log[2];
    int lk[2][16];
    int lc[2][16];
    int lba[2][16];
    int laddr[2][16];
    int done_cyc[2];
    int cke_viol[2];
    int post_cmd[2];
    int drop[2];
    logic prev_done[2];

    sdr_pwrup_seq #(.REF_COUNT(2), .MRS_FIRST(1'b1),
        .MODE_VAL(13'h0032), .EXT_MODE_VAL(13'h0020)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n[0]), .ras_n(ras_n[0]), .cas_n(cas_n[0]),
        .we_n(we_n[0]), .cke(cke[0]), .dqm(dqm[0]), .ba(ba[0]), .addr(addr[0]),
        .init_done(done[0]));

    sdr_pwrup_seq #(.REF_COUNT(3), .MRS_FIRST(1'b0),
        .MODE_VAL(13'h0023), .EXT_MODE_VAL(13'h0040)) dut_alt_i (
        .clk(clk), .rst(rst), .cs_n(cs_n[1]), .ras_n(ras_n[1]), .cas_n(cas_n[1]),
        .we_n(we_n[1]), .cke(cke[1]), .dqm(dqm[1]), .ba(ba[1]), .addr(addr[1]),
        .init_done(done[1]));

    function automatic int to_cyc(input int ns);
        int c;
        c = (ns * 1000 + PER_PS - 1) / PER_PS;
        if (c < 2) c = 2;
        return c;
    endfunction

    function automatic int decode(input int d);
        case ({cs_n[d], ras_n[d], cas_n[d], we_n[d]})
            4'b0111: return 0;
            4'b0010: return K_PALL;
            4'b0001: return K_REF;
            4'b0000: return (ba[d] == 2'b10) ? K_EMRS : ((ba[d] == 2'b00) ? K_MRS : K_BAD);
            default: return K_BAD;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    for (genvar d = 0; d < 2; d++) begin : g_mon
        always @(negedge clk) begin
            if (!rst) begin
                int k;
                k = decode(d);
                if (k != 0 && !done[d] && n_log[d] < 16) begin
                    lk[d][n_log[d]]    = k;
                    lc[d][n_log[d]]    = cyc;
                    lba[d][n_log[d]]   = int'(ba[d]);
                    laddr[d][n_log[d]] = int'(addr[d]);
                    n_log[d]           = n_log[d] + 1;
                end
                if (!done[d] && (!cke[d] || !dqm[d])) cke_viol[d] = cke_viol[d] + 1;
                if (done[d] && done_cyc[d] < 0) done_cyc[d] = cyc;
                if (done[d] && k != 0) post_cmd[d] = post_cmd[d] + 1;
                if (prev_done[d] && !done[d]) drop[d] = drop[d] + 1;
                prev_done[d] = done[d];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp,
                       input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        for (int d = 0; d < 2; d++) begin
            n_log[d] = 0; done_cyc[d] = -1; cke_viol[d] = 0;
            post_cmd[d] = 0; drop[d] = 0; prev_done[d] = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk({cs_n[d], ras_n[d], cas_n[d], we_n[d]} == 4'b0111, "R1",
                {cs_n[d], ras_n[d], cas_n[d], we_n[d]}, 7, "NOP during reset");
            chk(cke[d] && dqm[d], "R3", {cke[d], dqm[d]}, 3, "cke/dqm high during reset");
            chk(!done[d], "R10", done[d], 0, "init_done low in reset");
        end
    endtask

    task automatic release_and_wait();
        clear_logs();
        @(posedge clk); #2 rst = 1'b0;
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if (done_cyc[0] >= 0 && done_cyc[1] >= 0) break;
        end
    endtask

    task automatic check_sched(input int d, input bit mrs_first, input int refn,
                               input int mode, input int ext);
        int ek[16]; int ec[16]; int n; int t;
        n = 0; t = to_cyc(200000);
        ek[n] = K_PALL; ec[n] = t; n++; t += to_cyc(18);
        if (mrs_first) begin
            ek[n] = K_MRS;  ec[n] = t; n++; t += to_cyc(16);
            ek[n] = K_EMRS; ec[n] = t; n++; t += to_cyc(16);
        end
        for (int r = 0; r < refn; r++) begin
            ek[n] = K_REF; ec[n] = t; n++; t += to_cyc(60);
        end
        if (!mrs_first) begin
            ek[n] = K_MRS;  ec[n] = t; n++; t += to_cyc(16);
            ek[n] = K_EMRS; ec[n] = t; n++; t += to_cyc(16);
        end
        chk(n_log[d] == n, "R6", n_log[d], n, "number of commands (refresh count)");
        chk(lc[d][0] == ec[0], "R2", lc[d][0], ec[0], "first command cycle after pause");
        chk(lk[d][0] == K_PALL && laddr[d][0][10], "R4", lk[d][0], K_PALL,
            "precharge-all first with A10");
        for (int i = 0; i < n && i < n_log[d]; i++) begin
            chk(lk[d][i] == ek[i], "R7", lk[d][i], ek[i], $sformatf("kind of command %0d", i));
            chk(lc[d][i] == ec[i], "R8", lc[d][i], ec[i], $sformatf("cycle of command %0d", i));
            if (ek[i] == K_MRS)
                chk(lba[d][i] == 0 && laddr[d][i] == mode, "R5", laddr[d][i], mode, "mode load value");
            if (ek[i] == K_EMRS)
                chk(lba[d][i] == 2 && laddr[d][i] == ext, "R5", laddr[d][i], ext, "ext mode load value");
        end
        chk(done_cyc[d] == t, "R9", done_cyc[d], t, "init_done rise cycle");
        chk(cke_viol[d] == 0, "R3", cke_viol[d], 0, "cycles with cke/dqm low before done");
    endtask

    task automatic t_full_run();
        release_and_wait();
        check_sched(0, 1'b1, 2, 'h32, 'h20);
        check_sched(1, 1'b0, 3, 'h23, 'h40);
    endtask

    task automatic t_hold_after_done();
        repeat (20) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk(done[d] && drop[d] == 0, "R9", drop[d], 0, "init_done stays high");
            chk(post_cmd[d] == 0, "R1", post_cmd[d], 0, "commands after completion");
        end
    endtask

    task automatic t_restart_mid();
        clear_logs();
        rst = 1'b1;
        @(posedge clk); #2 rst = 1'b0;
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if (n_log[0] >= 2) break;
        end
        repeat (2) @(negedge clk);
        #2 rst = 1'b1;
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk(!done[d], "R10", done[d], 0, "init_done low after mid-sequence reset");
            chk({cs_n[d], ras_n[d], cas_n[d], we_n[d]} == 4'b0111, "R10",
                {cs_n[d], ras_n[d], cas_n[d], we_n[d]}, 7, "NOP after reset");
        end
        @(negedge clk);
        release_and_wait();
        chk(lc[0][0] == to_cyc(200000), "R10", lc[0][0], to_cyc(200000), "pause replayed in full");
        check_sched(0, 1'b1, 2, 'h32, 'h20);
        check_sched(1, 1'b0, 3, 'h23, 'h40);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        clear_logs();
        t_reset_state();
        t_full_run();
        t_hold_after_done();
        t_restart_mid();
        t_hold_after_done();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule